// File: doc/BRIEF.md
# Microcoded Bus Pattern Sequencer

The block drives the strobes of an external memory bus from a small pattern memory. Each 32-bit pattern word fixes, for every clock it is active, the level of the chip-select and write-enable strobes in each quarter of that clock and of output-enable in each half. The same word also holds:

- a repeat count, so one word lasts from one to four clocks;
- a loop-member mark;
- a transfer-acknowledge flag;
- a wait-enable flag that lets an external wait line stretch the word;
- an end mark that finishes the pattern.

The host uses a control register to choose the operation. In normal operation, an access by the requester starts the read pattern at word 0x00 or the write pattern at word 0x18. Two other operations load the pattern memory through the data register and read it back, one word per access, with the address stepping on its own. A fourth operation runs a pattern from the address held in the control register. A pair of adjacent loop-marked words is replayed as a unit. The number of passes comes from one of two programmable counts: the read count serves read patterns and run operation, the write count serves write patterns.

Top module: `bus_pattern_seq`

## Requirements
- R1: The control register keeps an operation code in bits 29:28 (00 normal, 01 load memory, 10 read memory, 11 run), a read loop count in bits 17:14, a write loop count in bits 13:10 and a pattern address in bits 5:0. Reading it back returns these fields in place and zero in all other bits.
- R2: With operation 01, each access stores the data register into the addressed word and then adds one to the address. The address wraps from 63 to 0.
- R3: With operation 10, each access copies the addressed word into the data register and then adds one to the address.
- R4: After reset, every pattern word holds the idle value 0xFF030001 and the control register reads zero. While no pattern runs, all strobe outputs are 1 (negated), the acknowledge output is 0 and busy is 0.
- R5: With operation 00, an access with acc_rnw=1 starts at word 0x00 and uses the read loop count. An access with acc_rnw=0 starts at word 0x18 and uses the write loop count. With operation 11, a pattern starts at the register's address and uses the read loop count. Busy and the first word appear in the clock after the access.
- R6: While busy, cs_q follows word bits 31:28, we_q follows bits 27:24, oe_h follows bits 17:16 and xfer_ack follows bit 2. Each word lasts (bits 9:8)+1 clocks.
- R7: A word with bit 0 set ends the pattern after its last clock. In the next clock busy is 0 and the outputs are idle.
- R8: Bit 7 marks a loop member. Two adjacent marked words run as a pair N times, where N is the selected loop count and a count of 0 means 16.
- R9: While the current word has bit 12 set and ext_wait is 1, the word's clock count does not advance. If bit 12 is clear, ext_wait has no effect.
- R10: If 64 words complete without an end mark, the sequencer returns to idle.
- R11: An access is ignored if it arrives while busy, or in the same cycle as a control-register or data-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write value |
| ctrl_rdata | output | 32 | Control register contents |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data register write value |
| data_rdata | output | 32 | Data register contents |
| acc_req | input | 1 | One-cycle bus access from the requester |
| acc_rnw | input | 1 | Access direction in normal operation, 1 read |
| ext_wait | input | 1 | External wait line, active high |
| cs_q | output | 4 | Chip-select level per clock quarter, 1 negated |
| we_q | output | 4 | Write-enable level per clock quarter, 1 negated |
| oe_h | output | 2 | Output-enable level per clock half, 1 negated |
| xfer_ack | output | 1 | Transfer acknowledge to the requester |
| busy | output | 1 | A pattern is running |

## Verification
Two events can fall in the same cycle: the wait line can be asserted on the final repeat clock of a wait-enabled word, which is exactly the cycle in which the word would otherwise hand over to its successor. The bench drives ext_wait from a per-cycle schedule so that the line is high at the start of the word, then low for one clock, then high again on the last repeat clock. It expects the word to stay on the pins, with acknowledge still high, for exactly the stalled clocks plus its repeat count. The same schedule keeps ext_wait high during the following word, which has no wait enable, to confirm that the line is ignored there. An access arriving during a running pattern is also placed mid-trace, and the trace must stay unchanged.

// File: rtl/bps_pkg.sv
package bps_pkg;
    localparam int ADDR_W     = 6;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 4;
    localparam logic [ADDR_W-1:0] RD_START = 6'h00;
    localparam logic [ADDR_W-1:0] WR_START = 6'h18;
    localparam logic [WORD_W-1:0] IDLE_WORD = 32'hFF03_0001;

    typedef enum logic [1:0] {
        OP_NORMAL = 2'b00,
        OP_LOAD   = 2'b01,
        OP_FETCH  = 2'b10,
        OP_RUN    = 2'b11
    } op_e;

    typedef struct packed {
        logic [3:0] cs;
        logic [3:0] we;
        logic [1:0] oe;
        logic       waen;
        logic [1:0] redo;
        logic       loop_m;
        logic       ack;
        logic       last;
    } pword_t;

    function automatic pword_t decode_word(input logic [WORD_W-1:0] w);
        pword_t d;
        d.cs     = w[31:28];
        d.we     = w[27:24];
        d.oe     = w[17:16];
        d.waen   = w[12];
        d.redo   = w[9:8];
        d.loop_m = w[7];
        d.ack    = w[2];
        d.last   = w[0];
        return d;
    endfunction
endpackage

// File: rtl/bps_pattern_ram.sv
module bps_pattern_ram
    import bps_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = WORD_W,
    parameter int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= DW'(IDLE_WORD);
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bps_host_regs.sv
module bps_host_regs
    import bps_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [DW-1:0] ctrl_wdata,
    output logic [DW-1:0] ctrl_rdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    output logic [DW-1:0] data_rdata,
    input  logic          acc_req,
    input  logic          acc_rnw,
    input  logic          busy,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [DW-1:0] ram_wdata,
    output logic          start,
    output logic [AW-1:0] start_addr,
    output logic [CW-1:0] start_cnt
);
    op_e           op;
    logic [CW-1:0] rd_cnt, wr_cnt;
    logic [AW-1:0] mad;
    logic [DW-1:0] dreg;
    logic          acc_ok;

    assign acc_ok = acc_req && !busy && !ctrl_we && !data_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            op     <= OP_NORMAL;
            rd_cnt <= '0;
            wr_cnt <= '0;
            mad    <= '0;
            dreg   <= '0;
        end else begin
            if (ctrl_we) begin
                op     <= op_e'(ctrl_wdata[29:28]);
                rd_cnt <= ctrl_wdata[17:14];
                wr_cnt <= ctrl_wdata[13:10];
                mad    <= ctrl_wdata[AW-1:0];
            end
            if (data_we) dreg <= data_wdata;
            if (acc_ok && (op == OP_LOAD || op == OP_FETCH)) begin
                mad <= mad + AW'(1);
                if (op == OP_FETCH) dreg <= ram_rdata;
            end
        end
    end

    always_comb begin
        ctrl_rdata          = '0;
        ctrl_rdata[29:28]   = op;
        ctrl_rdata[17:14]   = rd_cnt;
        ctrl_rdata[13:10]   = wr_cnt;
        ctrl_rdata[AW-1:0]  = mad;
    end

    assign data_rdata = dreg;
    assign ram_addr   = mad;
    assign ram_we     = acc_ok && (op == OP_LOAD);
    assign ram_wdata  = dreg;
    assign start      = acc_ok && (op == OP_NORMAL || op == OP_RUN);

    always_comb begin
        if (op == OP_RUN) begin
            start_addr = mad;
            start_cnt  = rd_cnt;
        end else if (acc_rnw) begin
            start_addr = RD_START;
            start_cnt  = rd_cnt;
        end else begin
            start_addr = WR_START;
            start_cnt  = wr_cnt;
        end
    end

    // R2
    load_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && op == OP_LOAD) |=> (mad == AW'($past(mad) + AW'(1))));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_req && busy && !ctrl_we && !data_we) |=> ($stable(mad) && $stable(dreg)));
endmodule

// File: rtl/bps_engine.sv
module bps_engine
    import bps_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = WORD_W,
    parameter int CW    = CNT_W,
    parameter int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] start_cnt,
    input  logic [DW-1:0] word,
    input  logic          ext_wait,
    output logic          busy,
    output logic [AW-1:0] ptr
);
    localparam int VW = $clog2(WORDS) + 1;
    localparam logic [VW-1:0] LIMIT = VW'(WORDS - 1);

    pword_t        w;
    logic [1:0]    rep;
    logic          loop_on;
    logic [AW-1:0] head;
    logic [CW-1:0] left;
    logic [CW-1:0] lcnt;
    logic [VW-1:0] visits;
    logic          stall;
    logic          done_word;

    assign w         = decode_word(word);
    assign stall     = w.waen && ext_wait;
    assign done_word = busy && !stall && (rep == w.redo);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ptr     <= '0;
            rep     <= '0;
            loop_on <= 1'b0;
            head    <= '0;
            left    <= '0;
            lcnt    <= '0;
            visits  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                ptr     <= start_addr;
                rep     <= '0;
                loop_on <= 1'b0;
                lcnt    <= start_cnt;
                visits  <= '0;
            end
        end else if (!stall) begin
            if (rep != w.redo) begin
                rep <= rep + 2'd1;
            end else begin
                rep <= '0;
                if (w.last || visits == LIMIT) begin
                    busy <= 1'b0;
                end else begin
                    visits <= visits + VW'(1);
                    if (w.loop_m && !loop_on) begin
                        loop_on <= 1'b1;
                        head    <= ptr;
                        left    <= (lcnt == '0) ? {CW{1'b1}} : lcnt - CW'(1);
                        ptr     <= ptr + AW'(1);
                    end else if (w.loop_m && ptr != head) begin
                        if (left != '0) begin
                            left <= left - CW'(1);
                            ptr  <= head;
                        end else begin
                            loop_on <= 1'b0;
                            ptr     <= ptr + AW'(1);
                        end
                    end else begin
                        ptr <= ptr + AW'(1);
                    end
                end
            end
        end
    end

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && stall) |=> (busy && ptr == $past(ptr) && rep == $past(rep)));

    // R7
    end_word_chk: assert property (@(posedge clk) disable iff (rst)
        (done_word && w.last) |=> !busy);

    // R6
    repeat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rep <= w.redo));

    // R10
    visit_limit_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (visits <= LIMIT));
endmodule

// File: rtl/bus_pattern_seq.sv
module bus_pattern_seq
    import bps_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [DW-1:0] ctrl_wdata,
    output logic [DW-1:0] ctrl_rdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    output logic [DW-1:0] data_rdata,
    input  logic          acc_req,
    input  logic          acc_rnw,
    input  logic          ext_wait,
    output logic [3:0]    cs_q,
    output logic [3:0]    we_q,
    output logic [1:0]    oe_h,
    output logic          xfer_ack,
    output logic          busy
);
    logic [AW-1:0] ram_addr, ptr, start_addr;
    logic          ram_we, start;
    logic [DW-1:0] ram_wdata, host_word, run_word;
    logic [CW-1:0] start_cnt;
    pword_t        cur;

    bps_pattern_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst(rst), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
        .raddr_a(ram_addr), .rdata_a(host_word),
        .raddr_b(ptr), .rdata_b(run_word)
    );

    bps_host_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .acc_req(acc_req), .acc_rnw(acc_rnw), .busy(busy),
        .ram_rdata(host_word), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .start(start), .start_addr(start_addr),
        .start_cnt(start_cnt)
    );

    bps_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_cnt(start_cnt), .word(run_word), .ext_wait(ext_wait),
        .busy(busy), .ptr(ptr)
    );

    assign cur      = decode_word(run_word);
    assign cs_q     = busy ? cur.cs  : 4'hF;
    assign we_q     = busy ? cur.we  : 4'hF;
    assign oe_h     = busy ? cur.oe  : 2'b11;
    assign xfer_ack = busy && cur.ack;

    // R4
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_q == 4'hF && we_q == 4'hF && oe_h == 2'b11 && !xfer_ack));

    // R5
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

// File: tb/bus_pattern_seq_test.sv
module bus_pattern_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctrl_we = 1'b0, data_we = 1'b0, acc_req = 1'b0, acc_rnw = 1'b0, ext_wait = 1'b0;
    logic [31:0] ctrl_wdata = '0, data_wdata = '0;
    logic [31:0] ctrl_rdata, data_rdata;
    logic [3:0]  cs_q, we_q;
    logic [1:0]  oe_h;
    logic        xfer_ack, busy;

    int checks = 0, fails = 0;
    int exp_q[$];
    bit wb_q[$];
    int poke_at;

    localparam logic [31:0] IDLE = 32'hFF03_0001;

    always #4 clk = ~clk;

    bus_pattern_seq uut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .data_we(data_we), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .acc_req(acc_req), .acc_rnw(acc_rnw),
        .ext_wait(ext_wait), .cs_q(cs_q), .we_q(we_q), .oe_h(oe_h),
        .xfer_ack(xfer_ack), .busy(busy)
    );

    function automatic logic [31:0] mkword(input logic [7:0] id, input logic [1:0] oe,
                                           input logic [1:0] redo, input bit lp,
                                           input bit ack, input bit waen, input bit last);
        return {id, 6'b0, oe, 3'b0, waen, 2'b0, redo, lp, 4'b0, ack, 1'b0, last};
    endfunction

    function automatic logic [31:0] mkctrl(input logic [1:0] op, input logic [3:0] rc,
                                           input logic [3:0] wc, input logic [5:0] a);
        return {2'b0, op, 10'b0, rc, wc, 4'b0, a};
    endfunction

    // expected trace code: {oe, ack, id}
    function automatic int code(input logic [7:0] id, input logic [1:0] oe, input bit ack);
        return int'({oe, ack, id});
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic load_word(input logic [31:0] v);
        data_we = 1'b1; data_wdata = v;
        @(negedge clk);
        data_we = 1'b0; acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic fetch_word(output logic [31:0] v);
        acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        v = data_rdata;
    endtask

    task automatic run_trace(input string req, input bit rnw);
        acc_req = 1'b1; acc_rnw = rnw;
        @(negedge clk);
        acc_req = 1'b0;
        for (int k = 0; k < exp_q.size(); k++) begin
            ext_wait = (k < wb_q.size()) ? wb_q[k] : 1'b0;
            chk(req, {20'b0, 1'b0, busy, oe_h, xfer_ack, cs_q, we_q},
                {20'b0, 1'b0, 1'b1, 11'(exp_q[k])});
            if (k == poke_at) acc_req = 1'b1;
            @(negedge clk);
            acc_req = 1'b0;
        end
        ext_wait = 1'b0;
        chk({req, " R7 idle after end"}, {busy, xfer_ack, oe_h, cs_q, we_q},
            {1'b0, 1'b0, 2'b11, 4'hF, 4'hF});
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 reset state
        chk("R4 pins", {busy, xfer_ack, oe_h, cs_q, we_q}, {1'b0, 1'b0, 2'b11, 4'hF, 4'hF});
        chk("R4 ctrl", ctrl_rdata, 32'h0);

        // R1 field placement
        wr_ctrl(32'hFFFF_FFFF);
        chk("R1 readback", ctrl_rdata, 32'h3003_FC3F);

        // R3 / R4 every word idle after reset, address wraps
        wr_ctrl(mkctrl(2'b10, 4'd0, 4'd0, 6'd0));
        for (int i = 0; i < 64; i++) begin
            fetch_word(v);
            chk("R4 R3 idle word", v, IDLE);
        end
        chk("R3 address wrap", {26'b0, ctrl_rdata[5:0]}, 32'h0);

        // Read pattern at 0x00
        wr_ctrl(mkctrl(2'b01, 4'd3, 4'd1, 6'h00));
        load_word(mkword(8'h10, 2'b10, 2'd1, 0, 0, 0, 0));
        load_word(mkword(8'h11, 2'b11, 2'd0, 1, 0, 0, 0));
        load_word(mkword(8'h12, 2'b01, 2'd1, 1, 0, 0, 0));
        load_word(mkword(8'h13, 2'b11, 2'd0, 0, 1, 0, 0));
        load_word(mkword(8'h14, 2'b00, 2'd0, 0, 0, 0, 1));
        chk("R2 address step", {26'b0, ctrl_rdata[5:0]}, 32'd5);

        // R11 access with data write in same cycle is ignored
        data_we = 1'b1; data_wdata = 32'h1234_5678; acc_req = 1'b1;
        @(negedge clk);
        data_we = 1'b0; acc_req = 1'b0;
        chk("R11 same-cycle address", {26'b0, ctrl_rdata[5:0]}, 32'd5);

        // Write pattern at 0x18
        wr_ctrl(mkctrl(2'b01, 4'd3, 4'd1, 6'h18));
        load_word(mkword(8'h20, 2'b11, 2'd0, 0, 0, 0, 0));
        load_word(mkword(8'h21, 2'b11, 2'd0, 1, 0, 0, 0));
        load_word(mkword(8'h22, 2'b11, 2'd0, 1, 0, 0, 0));
        load_word(mkword(8'h23, 2'b11, 2'd0, 0, 1, 0, 1));

        // Run-mode pattern at 0x30 with wait enable
        wr_ctrl(mkctrl(2'b01, 4'd3, 4'd1, 6'h30));
        load_word(mkword(8'h30, 2'b10, 2'd1, 0, 1, 1, 0));
        load_word(mkword(8'h31, 2'b11, 2'd0, 0, 0, 0, 1));

        // R3 readback of loaded words, R11 word 5 untouched
        wr_ctrl(mkctrl(2'b10, 4'd3, 4'd1, 6'h03));
        fetch_word(v);
        chk("R3 fetch word 3", v, mkword(8'h13, 2'b11, 2'd0, 0, 1, 0, 0));
        fetch_word(v);
        chk("R3 fetch word 4", v, mkword(8'h14, 2'b00, 2'd0, 0, 0, 0, 1));
        fetch_word(v);
        chk("R11 word 5 unchanged", v, IDLE);

        // R5 R6 R8 read pattern, loop count 3
        wr_ctrl(mkctrl(2'b00, 4'd3, 4'd1, 6'h00));
        exp_q = {};
        wb_q = {};
        poke_at = -1;
        exp_q.push_back(code(8'h10, 2'b10, 0));
        exp_q.push_back(code(8'h10, 2'b10, 0));
        for (int p = 0; p < 3; p++) begin
            exp_q.push_back(code(8'h11, 2'b11, 0));
            exp_q.push_back(code(8'h12, 2'b01, 0));
            exp_q.push_back(code(8'h12, 2'b01, 0));
        end
        exp_q.push_back(code(8'h13, 2'b11, 1));
        exp_q.push_back(code(8'h14, 2'b00, 0));
        run_trace("R5 R6 R8 read pattern", 1'b1);

        // R5 R8 R11 write pattern, write count 1, access during run
        exp_q = {};
        poke_at = 1;
        exp_q.push_back(code(8'h20, 2'b11, 0));
        exp_q.push_back(code(8'h21, 2'b11, 0));
        exp_q.push_back(code(8'h22, 2'b11, 0));
        exp_q.push_back(code(8'h23, 2'b11, 1));
        run_trace("R5 R8 R11 write pattern", 1'b0);

        // R8 count 0 means 16 passes
        wr_ctrl(mkctrl(2'b00, 4'd3, 4'd0, 6'h00));
        exp_q = {};
        poke_at = -1;
        exp_q.push_back(code(8'h20, 2'b11, 0));
        for (int p = 0; p < 16; p++) begin
            exp_q.push_back(code(8'h21, 2'b11, 0));
            exp_q.push_back(code(8'h22, 2'b11, 0));
        end
        exp_q.push_back(code(8'h23, 2'b11, 1));
        run_trace("R8 sixteen passes", 1'b0);

        // R9 wait, incl. assertion on the last repeat clock; R5 run mode
        wr_ctrl(mkctrl(2'b11, 4'd3, 4'd0, 6'h30));
        exp_q = {};
        wb_q = {1, 1, 0, 1, 0, 1};
        for (int k = 0; k < 5; k++) exp_q.push_back(code(8'h30, 2'b10, 1));
        exp_q.push_back(code(8'h31, 2'b11, 0));
        run_trace("R9 R5 wait stretch", 1'b0);
        wb_q = {};

        // R10 abort after 64 words without end
        wr_ctrl(mkctrl(2'b01, 4'd1, 4'd1, 6'h00));
        for (int i = 0; i < 64; i++) load_word(mkword(8'(i), 2'b11, 2'd0, 0, 0, 0, 0));
        chk("R2 wrap after 64 loads", {26'b0, ctrl_rdata[5:0]}, 32'h0);
        wr_ctrl(mkctrl(2'b11, 4'd1, 4'd1, 6'h00));
        exp_q = {};
        for (int i = 0; i < 64; i++) exp_q.push_back(code(8'(i), 2'b11, 0));
        run_trace("R10 no end mark", 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule